// File: doc/BRIEF.md
# Binary-to-Decimal Digit Generator

This block turns a signed double-word binary integer into a right-aligned field of decimal digit bytes and writes those bytes to memory through a destination byte pointer. A command carries the two source words, a flag/length word, the destination pointer, an 18-bit table base or signed offset, and a fill byte. A one-time setup stage takes the magnitude of the source, records the sign and the zero test in the flag/length word, and counts the decimal digits the magnitude needs. If the field is too short, the block stops without writing anything. Otherwise it may pad the front of the field with fill bytes and then produces the digits from the most significant one down.

Each digit is found by subtracting one power of ten at a time, one subtraction per clock, from a 71-bit working value. The stored byte is either the digit plus a sign-extended offset or a halfword read from a translation table indexed by the digit. Every store is a read-modify-write of the word the advanced pointer selects. A resume flag lets an interrupted conversion continue without repeating setup. On completion the block reports skip or no-skip together with the updated command words.

Top module: `bcd_digit_gen`

## Requirements
- R1: Bit 35 of the high source word is the sign. A negative 71-bit source (high word then the low 35 bits of the low word; low word bit 35 ignored) is converted as its magnitude. Setup sets the M flag (flag/length bit 33) for a negative source and the N flag (bit 34) for a nonzero source.
- R2: Setup counts the decimal digits of the magnitude, at least 1 and at most 22. With the L flag (bit 35) clear, the length field (bits 26:0) is replaced by that count, so exactly that many digits are written.
- R3: If the digit count exceeds the length field, the block finishes with skip=0, writes no memory, and returns the flag/length word and the pointer unchanged.
- R4: With L set and a length greater than the digit count, the surplus leading positions are written with the fill byte before any digit.
- R5: In offset mode (cmd_table_mode=0) each stored byte is the digit plus the 18-bit value sign-extended to 36 bits, truncated to 36 bits.
- R6: In table mode each byte is the right halfword (bits 17:0) of the word at table base + digit. For the last digit of the field with L set, the left halfword (bits 35:18) is used instead.
- R7: The pointer holds position P in bits 35:30, size S in bits 29:24 and the word address in bits 17:0. Each store first sets P to P-S; if the result is negative, it adds 1 to the address and sets P to 36-S. It then reads that word, replaces the S-bit field starting at bit P, and writes the word back to the same address.
- R8: Normal completion reports skip=1 with a length field of 0, the resume flag clear and the remaining source value zero.
- R9: A command with cmd_resume=1 skips setup. The source is taken as it is, with no sign handling and no flag or length change, and len digits are produced from the current length, including leading zeros.
- R10: The block never reads and writes in the same cycle, and it expects read data on mem_rdata in the cycle after mem_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Starts a conversion when idle |
| cmd_table_mode | input | 1 | 1: translation table, 0: offset |
| cmd_resume | input | 1 | Setup already done |
| cmd_src_hi | input | 36 | High source word |
| cmd_src_lo | input | 36 | Low source word (bit 35 ignored) |
| cmd_ctl | input | 36 | Flags and destination length |
| cmd_dptr | input | 36 | Destination byte pointer |
| cmd_tbl | input | 18 | Table base or signed offset |
| cmd_fill | input | 36 | Fill byte |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| skip | output | 1 | Completion status, valid with done |
| res_src_hi | output | 36 | Remaining value, high word |
| res_src_lo | output | 36 | Remaining value, low word |
| res_ctl | output | 36 | Updated flag/length word |
| res_dptr | output | 36 | Updated destination pointer |
| res_resume | output | 1 | Setup-done flag |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 36 | Write data |
| mem_rdata | input | 36 | Read data, one cycle after mem_rd |

## Verification
The bench builds the block with its default parameters: a 22-entry power-of-ten table and 18-bit addresses. With that table a 22-digit value just above 10^21 can be converted and the top table entry is used. It also reaches pointers that cross word boundaries, byte sizes from 6 to 18 bits, and table entries at 18-bit addresses that sit next to the destination words in a 64-word memory model.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int WORD_W = 36;
    localparam int HALF_W = 18;
    localparam int LEN_W  = 27;
    localparam int MAG_W  = 71;
    localparam int LO_W   = 35;
    localparam int FLAG_L = 35;
    localparam int FLAG_N = 34;
    localparam int FLAG_M = 33;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SETUP, ST_FILL, ST_NEXT, ST_SUB,
        ST_TBL_RD, ST_TBL_GET, ST_ST_RD, ST_ST_WR
    } conv_state_e;

    typedef struct packed {
        logic [5:0]  pos;
        logic [5:0]  size;
        logic [5:0]  spare;
        logic [17:0] addr;
    } byte_ptr_t;

    function automatic logic [MAG_W-1:0] pow10(input int k);
        logic [MAG_W-1:0] r;
        r = MAG_W'(1);
        for (int i = 0; i < k; i++) r = r * MAG_W'(10);
        return r;
    endfunction
endpackage

// File: rtl/bcd_pow_rom.sv
module bcd_pow_rom
    import bcd_pkg::*;
#(
    parameter int DEPTH = 22,
    localparam int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [MAG_W-1:0] val
);
    logic [MAG_W-1:0] tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        assign tbl[k] = pow10(k);
    end

    always_comb begin
        val = '0;
        for (int k = 0; k < DEPTH; k++)
            if (idx == IDX_W'(k)) val = tbl[k];
    end
endmodule

// File: rtl/bcd_sizer.sv
module bcd_sizer
    import bcd_pkg::*;
#(
    parameter int DEPTH = 22,
    localparam int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic [MAG_W-1:0] raw,
    output logic             neg,
    output logic             nonzero,
    output logic [MAG_W-1:0] mag,
    output logic [IDX_W-1:0] ndig
);
    logic [DEPTH-1:0] ge;

    assign neg     = raw[MAG_W-1];
    assign mag     = neg ? (~raw + MAG_W'(1)) : raw;
    assign nonzero = |raw;
    assign ge[0]   = 1'b0;

    for (genvar k = 1; k < DEPTH; k++) begin : g_cmp
        assign ge[k] = (mag >= pow10(k));
    end

    always_comb begin
        ndig = IDX_W'(1);
        for (int k = 0; k < DEPTH; k++) ndig = ndig + IDX_W'(ge[k]);
    end
endmodule

// File: rtl/bcd_byte_path.sv
module bcd_byte_path
    import bcd_pkg::*;
(
    input  byte_ptr_t         ptr,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] byte_val,
    output byte_ptr_t         ptr_next,
    output logic [WORD_W-1:0] new_word
);
    logic signed [7:0] pos_dec;
    logic [71:0]       mask_w;
    logic [71:0]       val_w;

    always_comb begin
        pos_dec  = $signed({2'b00, ptr.pos}) - $signed({2'b00, ptr.size});
        ptr_next = ptr;
        if (pos_dec < 0) begin
            ptr_next.addr = ptr.addr + 18'd1;
            ptr_next.pos  = 6'd36 - ptr.size;
        end else begin
            ptr_next.pos  = pos_dec[5:0];
        end
    end

    always_comb begin
        mask_w   = ((72'd1 << ptr.size) - 72'd1) << ptr.pos;
        val_w    = {36'd0, byte_val} << ptr.pos;
        new_word = (old_word & ~mask_w[WORD_W-1:0]) | (val_w[WORD_W-1:0] & mask_w[WORD_W-1:0]);
    end
endmodule

// File: rtl/bcd_digit_gen.sv
module bcd_digit_gen
    import bcd_pkg::*;
#(
    parameter int MAX_DIG = 22,
    parameter int ADDR_W  = 18,
    localparam int CNT_W  = $clog2(MAX_DIG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_table_mode,
    input  logic              cmd_resume,
    input  logic [WORD_W-1:0] cmd_src_hi,
    input  logic [WORD_W-1:0] cmd_src_lo,
    input  logic [WORD_W-1:0] cmd_ctl,
    input  logic [WORD_W-1:0] cmd_dptr,
    input  logic [HALF_W-1:0] cmd_tbl,
    input  logic [WORD_W-1:0] cmd_fill,
    output logic              busy,
    output logic              done,
    output logic              skip,
    output logic [WORD_W-1:0] res_src_hi,
    output logic [WORD_W-1:0] res_src_lo,
    output logic [WORD_W-1:0] res_ctl,
    output logic [WORD_W-1:0] res_dptr,
    output logic              res_resume,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    conv_state_e       st;
    logic [MAG_W-1:0]  rem;
    logic [WORD_W-1:0] ctl, fill_q, byte_q;
    byte_ptr_t         dptr, ptr_next;
    logic [HALF_W-1:0] tbl_q;
    logic              tbl_mode, fpd, from_fill, done_q, skip_q;
    logic [CNT_W-1:0]  ndig_q, cap, ndig;
    logic [3:0]        dig;
    logic [LEN_W-1:0]  len;
    logic [MAG_W-1:0]  pw, mag;
    logic              neg, nonzero;
    logic [WORD_W-1:0] ins_word;

    assign len = ctl[LEN_W-1:0];
    assign cap = (len > LEN_W'(MAX_DIG)) ? CNT_W'(MAX_DIG) : len[CNT_W-1:0];

    bcd_pow_rom #(.DEPTH(MAX_DIG)) u_rom (.idx(cap - CNT_W'(1)), .val(pw));

    bcd_sizer #(.DEPTH(MAX_DIG)) u_size (
        .raw(rem), .neg(neg), .nonzero(nonzero), .mag(mag), .ndig(ndig));

    bcd_byte_path u_path (
        .ptr(dptr), .old_word(mem_rdata), .byte_val(byte_q),
        .ptr_next(ptr_next), .new_word(ins_word));

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_TBL_RD: begin mem_rd = 1'b1; mem_addr = tbl_q + ADDR_W'(dig); end
            ST_ST_RD:  begin mem_rd = 1'b1; mem_addr = ptr_next.addr; end
            ST_ST_WR:  begin mem_wr = 1'b1; mem_addr = dptr.addr; mem_wdata = ins_word; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; rem <= '0; ctl <= '0; dptr <= '0; fill_q <= '0;
            byte_q <= '0; tbl_q <= '0; tbl_mode <= 1'b0; fpd <= 1'b0;
            from_fill <= 1'b0; done_q <= 1'b0; skip_q <= 1'b0;
            ndig_q <= '0; dig <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (cmd_start) begin
                    rem      <= {cmd_src_hi, cmd_src_lo[LO_W-1:0]};
                    ctl      <= cmd_ctl;
                    dptr     <= cmd_dptr;
                    tbl_q    <= cmd_tbl;
                    tbl_mode <= cmd_table_mode;
                    fill_q   <= cmd_fill;
                    fpd      <= cmd_resume;
                    st       <= cmd_resume ? ST_NEXT : ST_SETUP;
                end
                ST_SETUP: begin
                    if (LEN_W'(ndig) > len) begin
                        done_q <= 1'b1; skip_q <= 1'b0; st <= ST_IDLE;
                    end else begin
                        rem <= mag;
                        fpd <= 1'b1;
                        ctl[FLAG_M] <= ctl[FLAG_M] | neg;
                        ctl[FLAG_N] <= ctl[FLAG_N] | nonzero;
                        if (ctl[FLAG_L] && LEN_W'(ndig) < len) begin
                            ndig_q <= ndig; st <= ST_FILL;
                        end else begin
                            ctl[LEN_W-1:0] <= LEN_W'(ndig); st <= ST_NEXT;
                        end
                    end
                end
                ST_FILL: begin
                    if (len == LEN_W'(ndig_q)) st <= ST_NEXT;
                    else begin byte_q <= fill_q; from_fill <= 1'b1; st <= ST_ST_RD; end
                end
                ST_NEXT: begin
                    if (len == '0) begin
                        done_q <= 1'b1; skip_q <= 1'b1; fpd <= 1'b0; st <= ST_IDLE;
                    end else begin
                        dig <= '0; st <= ST_SUB;
                    end
                end
                ST_SUB: begin
                    if (dig < 4'd10 && rem >= pw) begin
                        rem <= rem - pw; dig <= dig + 4'd1;
                    end else if (tbl_mode) begin
                        st <= ST_TBL_RD;
                    end else begin
                        byte_q    <= {{HALF_W{tbl_q[HALF_W-1]}}, tbl_q} + WORD_W'(dig);
                        from_fill <= 1'b0;
                        st        <= ST_ST_RD;
                    end
                end
                ST_TBL_RD: st <= ST_TBL_GET;
                ST_TBL_GET: begin
                    byte_q <= (cap == CNT_W'(1) && ctl[FLAG_L])
                              ? {{HALF_W{1'b0}}, mem_rdata[WORD_W-1:HALF_W]}
                              : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
                    from_fill <= 1'b0;
                    st <= ST_ST_RD;
                end
                ST_ST_RD: begin dptr <= ptr_next; st <= ST_ST_WR; end
                ST_ST_WR: begin
                    ctl[LEN_W-1:0] <= len - LEN_W'(1);
                    st <= from_fill ? ST_FILL : ST_NEXT;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign done       = done_q;
    assign skip       = skip_q;
    assign res_src_hi = rem[MAG_W-1:LO_W];
    assign res_src_lo = {1'b0, rem[LO_W-1:0]};
    assign res_ctl    = ctl;
    assign res_dptr   = dptr;
    assign res_resume = fpd;

    assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    assert_store_rmw_R7: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));
    assert_skip_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (done && skip) |-> (res_ctl[LEN_W-1:0] == '0 && !res_resume && res_src_hi == '0));
    assert_oversize_noskip_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETUP && LEN_W'(ndig) > len) |=> (done && !skip && !mem_wr));
    assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETUP) |-> (ndig >= CNT_W'(1) && ndig <= CNT_W'(MAX_DIG)));
    assert_digit_max_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUB && dig == 4'd9) |-> (rem < pw));
endmodule

// File: tb/bcd_digit_gen_test.sv
module bcd_digit_gen_test;
    localparam int AW = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        cmd_start = 1'b0, cmd_table_mode = 1'b0, cmd_resume = 1'b0;
    logic [35:0] cmd_src_hi = '0, cmd_src_lo = '0, cmd_ctl = '0, cmd_dptr = '0, cmd_fill = '0;
    logic [17:0] cmd_tbl = '0;
    logic        busy, done, skip, res_resume, mem_rd, mem_wr;
    logic [35:0] res_src_hi, res_src_lo, res_ctl, res_dptr, mem_wdata;
    logic [35:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;

    bcd_digit_gen uut (.*);

    logic [35:0] mem [64];
    logic [35:0] exp_mem [64];
    logic        tb_we = 1'b0;
    logic [5:0]  tb_addr = '0;
    logic [35:0] tb_data = '0;

    always @(posedge clk) begin
        if (tb_we) mem[tb_addr] <= tb_data;
        if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
        if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
    end

    typedef struct {
        string       tag;
        logic        skip;
        logic [35:0] ctl;
        logic [35:0] dptr;
        logic        resume;
    } exp_t;
    exp_t sb [$];

    int total = 0, bad = 0, seen = 0;

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [35:0] mkptr(input int p, input int s, input int a);
        return {6'(p), 6'(s), 6'd0, 18'(a)};
    endfunction

    function automatic logic [35:0] adv(input logic [35:0] ptr);
        int p = int'(ptr[35:30]) - int'(ptr[29:24]);
        if (p < 0) return {6'(36 - int'(ptr[29:24])), ptr[29:24], ptr[23:18], ptr[17:0] + 18'd1};
        return {6'(p), ptr[29:24], ptr[23:0]};
    endfunction

    task automatic model_store(inout logic [35:0] ptr, input logic [35:0] b);
        logic [71:0] m;
        ptr = adv(ptr);
        m = ((72'd1 << ptr[29:24]) - 72'd1) << ptr[35:30];
        exp_mem[ptr[5:0]] = (exp_mem[ptr[5:0]] & ~m[35:0]) |
                            (m[35:0] & 36'(({36'd0, b} << ptr[35:30])));
    endtask

    task automatic preload(input int a, input logic [35:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = 6'(a); tb_data = d;
        exp_mem[a] = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic run_op(input string tag, input logic tmode, input logic res,
                          input logic [70:0] v, input logic [35:0] ctl,
                          input logic [35:0] dptr, input logic [17:0] tbl,
                          input logic [35:0] fill);
        exp_t e;
        logic [70:0] mag, t, p10;
        logic [35:0] c, ptr, w, b;
        int n, len, digits, nfill, d, want;
        e.tag = tag;
        c = ctl; ptr = dptr; len = int'(ctl[26:0]);
        mag = (!res && v[70]) ? -v : v;
        n = 1; t = mag;
        while (t >= 71'd10) begin t = t / 71'd10; n++; end
        if (!res && n > len) begin
            e.skip = 1'b0; e.ctl = ctl; e.dptr = dptr; e.resume = 1'b0;
        end else begin
            nfill = 0;
            digits = res ? len : n;
            if (!res) begin
                if (v[70]) c[33] = 1'b1;
                if (v != 0) c[34] = 1'b1;
                if (ctl[35] && n < len) nfill = len - n;
            end
            for (int i = 0; i < nfill; i++) model_store(ptr, fill);
            for (int pos = digits - 1; pos >= 0; pos--) begin
                p10 = 71'd1;
                for (int k = 0; k < pos; k++) p10 = p10 * 71'd10;
                d = int'((mag / p10) % 71'd10);
                if (tmode) begin
                    w = exp_mem[6'(18'(tbl) + 18'(d))];
                    b = (pos == 0 && ctl[35]) ? {18'd0, w[35:18]} : {18'd0, w[17:0]};
                end else begin
                    b = {{18{tbl[17]}}, tbl} + 36'(d);
                end
                model_store(ptr, b);
            end
            c[26:0] = '0;
            e.skip = 1'b1; e.ctl = c; e.dptr = ptr; e.resume = 1'b0;
        end
        sb.push_back(e);
        want = seen + 1;
        @(negedge clk);
        cmd_start = 1'b1; cmd_table_mode = tmode; cmd_resume = res;
        cmd_src_hi = v[70:35]; cmd_src_lo = {1'b0, v[34:0]};
        cmd_ctl = ctl; cmd_dptr = dptr; cmd_tbl = tbl; cmd_fill = fill;
        @(negedge clk);
        cmd_start = 1'b0;
        while (seen < want) @(negedge clk);
    endtask

    // monitor: pops the expected item when done pulses
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " skip"}, 36'(skip), 36'(e.skip));
                check({e.tag, " ctl"}, res_ctl, e.ctl);
                check({e.tag, " dptr"}, res_dptr, e.dptr);
                check({e.tag, " resume"}, 36'(res_resume), 36'(e.resume));
                for (int a = 0; a < 40; a++)
                    if (mem[a] !== exp_mem[a]) check({e.tag, " mem"}, mem[a], exp_mem[a]);
                total++;
                seen++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 64; a++) begin mem[a] = '0; exp_mem[a] = '0; end
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset busy", 36'(busy), 36'd0);
        check("R10 reset done", 36'(done), 36'd0);
        check("R10 reset rd", 36'(mem_rd), 36'd0);
        check("R10 reset wr", 36'(mem_wr), 36'd0);
        rst = 1'b0;
        for (int k = 0; k < 10; k++)
            preload(40 + k, {18'(200 + k), 18'(100 + k)});
        run_op("R5 R7 R8 basic", 1'b0, 1'b0, 71'd12345, 36'd5, mkptr(36, 7, 8), 18'd48, 36'd0);
        run_op("R1 negative", 1'b0, 1'b0, -71'd907, 36'd3, mkptr(36, 9, 12), 18'd48, 36'd0);
        run_op("R2 length trim", 1'b0, 1'b0, 71'd305, 36'd10, mkptr(36, 6, 14), 18'd48, 36'd0);
        run_op("R4 left fill", 1'b0, 1'b0, 71'd42, {1'b1, 8'd0, 27'd6}, mkptr(36, 8, 16), 18'd48, 36'd32);
        run_op("R3 too short", 1'b0, 1'b0, 71'd123456, 36'd3, mkptr(36, 7, 20), 18'd48, 36'd0);
        run_op("R6 table right", 1'b1, 1'b0, 71'd305, 36'd3, mkptr(36, 12, 22), 18'd40, 36'd0);
        run_op("R6 table left last", 1'b1, 1'b0, 71'd7, {1'b1, 8'd0, 27'd4}, mkptr(36, 18, 24), 18'd40, 36'd9);
        run_op("R2 zero", 1'b0, 1'b0, 71'd0, 36'd1, mkptr(36, 7, 26), 18'd48, 36'd0);
        run_op("R2 22 digits", 1'b0, 1'b0, 71'd1000000000000000000005, 36'd22, mkptr(36, 6, 28), 18'd0, 36'd0);
        run_op("R5 negative offset", 1'b0, 1'b0, 71'd10, 36'd2, mkptr(36, 12, 32), 18'h3FFFF, 36'd0);
        run_op("R9 resume", 1'b0, 1'b1, 71'd57, 36'd4, mkptr(36, 9, 34), 18'd48, 36'd0);
        run_op("R7 word cross", 1'b0, 1'b0, 71'd9, 36'd1, mkptr(5, 7, 36), 18'd48, 36'd0);
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule